// File: doc/BRIEF.md
# Key Acquisition Trigger Scheduler

This block decides the clock cycle in which a key-measurement cycle begins. It issues a one-cycle start pulse to the measurement engine. It keeps a busy state from that pulse until the engine raises its cycle-done flag. While that state is set, no further start is issued.

There are two trigger sources. In timed mode, a programmed repeat value sets the interval between starts in 16 ms ticks. A prescaler derives the tick from the system clock frequency parameter. A repeat value of zero gives free-running operation, in which each cycle follows the previous one as soon as it completes.

In synchronized mode, an external sync line starts each cycle. A select bit chooses between two trigger types: a low level on the line, or a rising edge. The line is resynchronized before it is used. Synchronized mode takes one sense pin away from the key array, and a status flag tells the rest of the sensor that only ten keys are usable.

Top module: `acq_trigger_sched`

## Requirements
- R1: While reset is asserted, start_pulse is 0. After reset release in timed mode with repeat value N > 0, the first start_pulse is observed exactly N*T cycles after release, where T is the tick length in clock cycles. It is absent before that point.
- R2: In timed mode with N > 0, consecutive starts are exactly N*T cycles apart whenever each cycle completes before its interval expires.
- R3: In timed mode with N = 0, a start follows every completion. With cycle_done raised in the cycle after a start, starts are 2 cycles apart.
- R4: start_pulse is never high in two consecutive cycles.
- R5: No start is issued from a start until cycle_done is sampled high. If a trigger is due during that time, the start is issued in the second cycle after the cycle in which cycle_done is high.
- R6: In synchronized mode (timed_en = 0) with sync_edge_sel = 0, a low synchronized sync level starts a cycle when idle. The line is high when inactive. After a completion, a new start is issued only while the line is still low.
- R7: In synchronized mode with sync_edge_sel = 1, only a low-to-high transition triggers, and a steady low level does not. A transition seen while busy is held, and is issued after completion; no more than one is held.
- R8: A sync change applied before clock edge a produces its start_pulse in the cycle that follows edge a+2. This latency comes from the two synchronizer flops plus the output register.
- R9: sync_pin_used is 1 when timed_en = 0 (key count capped at ten) and 0 when timed_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timed_en | input | 1 | 1 = internal interval trigger, 0 = external sync trigger |
| sync_edge_sel | input | 1 | 0 = low-level sync trigger, 1 = rising-edge sync trigger |
| repeat_val | input | RPT_W | Repeat interval in 16 ms ticks; 0 = free run |
| sync_in | input | 1 | Asynchronous external sync line |
| cycle_done | input | 1 | Completion flag from the measurement engine |
| start_pulse | output | 1 | One-cycle start request to the measurement engine |
| sync_pin_used | output | 1 | High when one key pin serves as sync, capping keys at ten |

## Verification
Each result has a fixed due cycle:
- A start that a due interval allows appears in the cycle after the deciding edge.
- A completion frees the next start in the second cycle after cycle_done is high.
- A sync change reaches start_pulse three edges after it is applied.
- In timed mode, the first start comes N*T cycles after reset release.

The bench drives inputs and samples outputs on the falling edge. It counts falling edges from each stimulus and checks the output at exactly the due count. It also checks that the output stays low on the counts before it.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  // Encoding of the sync trigger select bit.
  typedef enum logic {
    SYNC_LOW_LEVEL = 1'b0,
    SYNC_RISE_EDGE = 1'b1
  } sync_kind_e;

  // Clock cycles per tick, never below one.
  function automatic int tick_len(input longint clk_hz, input longint tick_ms);
    longint cyc;
    cyc = (clk_hz * tick_ms) / 1000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/acq_tick_prescaler.sv
module acq_tick_prescaler #(
  parameter int TICK_CYCLES = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/acq_elapsed_tracker.sv
module acq_elapsed_tracker #(
  parameter int RPT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [RPT_W-1:0] repeat_val,
  output logic             due
);
  localparam logic [RPT_W-1:0] SAT = '1;

  logic [RPT_W-1:0] elapsed_q, elapsed_d;
  logic             cnt_en;
  logic [RPT_W:0]   elapsed_ahead;

  assign cnt_en        = tick && (elapsed_q != SAT);
  assign elapsed_ahead = {1'b0, elapsed_q} + 1'b1;

  // Due now, or due as this tick completes the interval.
  assign due = (elapsed_q >= repeat_val) ||
               (tick && (elapsed_ahead >= {1'b0, repeat_val}));

  always_comb begin
    if (clr)         elapsed_d = '0;
    else if (cnt_en) elapsed_d = elapsed_q + 1'b1;
    else             elapsed_d = elapsed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed_q <= '0;
    else        elapsed_q <= elapsed_d;
  end
endmodule

// File: rtl/acq_sync_front.sv
module acq_sync_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic sync_lvl,
  output logic sync_rise
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  // Idle-high reset so a line held high gives no edge.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = sync_raw;
    end else begin : g_next
      assign d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b1;
      else        stage_q[g] <= d;
    end
  end

  assign sync_lvl  = stage_q[SYNC_STAGES-1];
  assign sync_rise = sync_lvl && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_lvl;
  end
endmodule

// File: rtl/acq_trigger_sched.sv
module acq_trigger_sched
  import acq_trig_pkg::*;
#(
  parameter int CLK_HZ      = 1000000,
  parameter int TICK_MS     = 16,
  parameter int RPT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timed_en,
  input  logic             sync_edge_sel,
  input  logic [RPT_W-1:0] repeat_val,
  input  logic             sync_in,
  input  logic             cycle_done,
  output logic             start_pulse,
  output logic             sync_pin_used
);
  localparam int TICK_CYCLES = tick_len(CLK_HZ, TICK_MS);

  logic       tick, due, sync_lvl, sync_rise;
  logic       busy_q, busy_d, pend_q, pend_d, start_q, start_d;
  logic       req, fire;
  sync_kind_e kind;

  assign kind = sync_kind_e'(sync_edge_sel);

  acq_tick_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(fire), .tick(tick)
  );

  acq_elapsed_tracker #(.RPT_W(RPT_W)) u_elapsed (
    .clk(clk), .rst_n(rst_n), .clr(fire), .tick(tick),
    .repeat_val(repeat_val), .due(due)
  );

  acq_sync_front #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_raw(sync_in),
    .sync_lvl(sync_lvl), .sync_rise(sync_rise)
  );

  // Trigger request by source.
  always_comb begin
    if (timed_en)                    req = due;
    else if (kind == SYNC_RISE_EDGE) req = sync_rise || pend_q;
    else                             req = !sync_lvl;
  end

  assign fire = req && !busy_q;

  always_comb begin
    start_d = fire;
    if (fire)            busy_d = 1'b1;
    else if (cycle_done) busy_d = 1'b0;
    else                 busy_d = busy_q;

    if (timed_en || kind != SYNC_RISE_EDGE) pend_d = 1'b0;
    else if (fire)                          pend_d = 1'b0;
    else if (sync_rise)                     pend_d = 1'b1;
    else                                    pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      busy_q  <= busy_d;
      pend_q  <= pend_d;
    end
  end

  assign start_pulse   = start_q;
  assign sync_pin_used = !timed_en;
endmodule

// File: rtl/acq_trigger_sched_chk.sv
module acq_trigger_sched_chk #(
  parameter int RPT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             timed_en,
  input logic             sync_edge_sel,
  input logic [RPT_W-1:0] repeat_val,
  input logic             cycle_done,
  input logic             start_pulse,
  input logic             busy_q,
  input logic             sync_lvl
);
  // R4
  single_cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R5
  start_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(busy_q));

  // R5
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cycle_done) |=> busy_q);

  // R3
  free_run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_en && repeat_val == '0 && !busy_q) |=> start_pulse);

  // R6
  low_level_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timed_en && !sync_edge_sel && !busy_q && !sync_lvl) |=> start_pulse);
endmodule

bind acq_trigger_sched acq_trigger_sched_chk #(.RPT_W(RPT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .timed_en(timed_en), .sync_edge_sel(sync_edge_sel),
  .repeat_val(repeat_val), .cycle_done(cycle_done), .start_pulse(start_pulse),
  .busy_q(busy_q), .sync_lvl(sync_lvl)
);

// File: tb/acq_trigger_sched_bench.sv
module acq_trigger_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RPT_W      = 4;
  localparam int TB_CLK_HZ  = 500;   // 8 cycles per 16 ms tick
  localparam int NVEC       = 4;
  // {repeat value, expected period in cycles}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd0, 8'd2}, {4'd1, 8'd8}, {4'd3, 8'd24}, {4'd15, 8'd120}
  };

  logic             clk, rst_n, timed_en, sync_edge_sel, sync_in, cycle_done;
  logic [RPT_W-1:0] repeat_val;
  logic             start_pulse, sync_pin_used;
  logic             auto_done;
  int               n_chk, n_fail;

  acq_trigger_sched #(.CLK_HZ(TB_CLK_HZ), .RPT_W(RPT_W)) u_acq_trigger_sched (
    .clk(clk), .rst_n(rst_n), .timed_en(timed_en), .sync_edge_sel(sync_edge_sel),
    .repeat_val(repeat_val), .sync_in(sync_in), .cycle_done(cycle_done),
    .start_pulse(start_pulse), .sync_pin_used(sync_pin_used)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic wait_start(input int max, output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (!start_pulse && n <= max);
  endtask

  task automatic count_starts(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      step(1);
      if (start_pulse) cnt++;
    end
  endtask

  task automatic done_pulse();
    cycle_done = 1'b1;
    step(1);
    cycle_done = 1'b0;
  endtask

  // Completion responder used by the vector loop.
  initial begin
    forever begin
      @(negedge clk);
      if (auto_done) cycle_done = start_pulse;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int n1, n2, cnt;
    n_chk = 0; n_fail = 0; auto_done = 1'b0;
    rst_n = 1'b0; timed_en = 1'b1; sync_edge_sel = 1'b0;
    repeat_val = 4'd2; sync_in = 1'b1; cycle_done = 1'b0;

    // R1 / R9: reset state and mode flag
    step(2);
    chk(start_pulse == 1'b0, "R1", start_pulse, 0);
    chk(sync_pin_used == 1'b0, "R9", sync_pin_used, 0);
    timed_en = 1'b0; #1;
    chk(sync_pin_used == 1'b1, "R9", sync_pin_used, 1);
    timed_en = 1'b1;

    // R1 R2 R3: interval vectors
    auto_done = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      repeat_val = VEC[v][11:8];
      apply_reset();
      wait_start(300, n1);
      if (VEC[v][11:8] != 0)
        chk(n1 == int'(VEC[v][7:0]), "R1", n1, int'(VEC[v][7:0]));
      wait_start(300, n2);
      if (VEC[v][11:8] == 0) chk(n2 == int'(VEC[v][7:0]), "R3", n2, int'(VEC[v][7:0]));
      else                   chk(n2 == int'(VEC[v][7:0]), "R2", n2, int'(VEC[v][7:0]));
    end
    auto_done = 1'b0;
    step(2);
    cycle_done = 1'b0;

    // R5: hold-off while busy
    repeat_val = 4'd1;
    apply_reset();
    wait_start(20, n1);
    chk(n1 == 8, "R1", n1, 8);
    count_starts(30, cnt);
    chk(cnt == 0, "R5", cnt, 0);
    done_pulse();
    chk(start_pulse == 1'b0, "R5", start_pulse, 0);
    step(1);
    chk(start_pulse == 1'b1, "R5", start_pulse, 1);
    step(1);
    chk(start_pulse == 1'b0, "R4", start_pulse, 0);

    // R6 / R8: low-level sync mode
    timed_en = 1'b0; sync_edge_sel = 1'b0; sync_in = 1'b1;
    apply_reset();
    count_starts(20, cnt);
    chk(cnt == 0, "R6", cnt, 0);
    sync_in = 1'b0;
    step(2);
    chk(start_pulse == 1'b0, "R8", start_pulse, 0);
    step(1);
    chk(start_pulse == 1'b1, "R8", start_pulse, 1);
    count_starts(10, cnt);
    chk(cnt == 0, "R6", cnt, 0);
    done_pulse();
    chk(start_pulse == 1'b0, "R6", start_pulse, 0);
    step(1);
    chk(start_pulse == 1'b1, "R6", start_pulse, 1);
    sync_in = 1'b1;
    step(4);
    done_pulse();
    count_starts(20, cnt);
    chk(cnt == 0, "R6", cnt, 0);

    // R7: rising-edge sync mode
    sync_edge_sel = 1'b1; sync_in = 1'b1;
    apply_reset();
    count_starts(20, cnt);
    chk(cnt == 0, "R7", cnt, 0);
    sync_in = 1'b0;
    count_starts(20, cnt);
    chk(cnt == 0, "R7", cnt, 0);
    sync_in = 1'b1;
    step(2);
    chk(start_pulse == 1'b0, "R8", start_pulse, 0);
    step(1);
    chk(start_pulse == 1'b1, "R8", start_pulse, 1);
    sync_in = 1'b0;
    count_starts(3, cnt);
    sync_in = 1'b1;
    count_starts(5, n2);
    chk(cnt + n2 == 0, "R7", cnt + n2, 0);
    done_pulse();
    chk(start_pulse == 1'b0, "R7", start_pulse, 0);
    step(1);
    chk(start_pulse == 1'b1, "R7", start_pulse, 1);
    done_pulse();
    count_starts(20, cnt);
    chk(cnt == 0, "R7", cnt, 0);

    summary();
  end
endmodule